// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block drives one pulse-width-modulated output from an 8-bit time base. The time base advances once every 4 × prescale clocks, and the prescale is 1, 4 or 16. The time base wraps after it reaches a programmable period value. At each wrap the output goes to its active level. It returns to the inactive level when a 10-bit duty value matches the time base extended by two sub-count bits. Those two bits come from the fast divider stage, so one duty step lasts prescale clocks.

Software writes a small register file through a plain address, data and write-strobe port. The write port is a control path: it has no valid/ready handshake and it accepts a write on every cycle. Every setting goes into a write buffer and reaches the waveform logic only at a period wrap. Writes made in the middle of a period therefore never disturb the pulse in progress. An optional dead band delays the active edge by a programmable number of clocks.

Top module: `pwm10_gen`

## Requirements
- R1: One period lasts (P + 1) × 4 × prescale clocks, where P is the period register (address 0). The time base returns to zero on the step after it equals P.
- R2: The duty value may be written at any time. A new duty value is first used at the next wrap, so the pulse already in progress keeps its old length.
- R3: The duty value is 10 bits. Bits 9..2 come from address 1 and bits 1..0 from control (address 2) bits 1..0. With duty D, the output stays active for D × prescale clocks starting at the wrap.
- R4: Control bits 3..2 select the prescale: 00 gives 1, 01 gives 4, 10 and 11 give 16.
- R5: A latched duty of 0 keeps the output inactive for the whole period.
- R6: A latched duty above 4 × P + 3 is never matched, so the output stays active for the whole period.
- R7: Control bit 4 set to 1 makes the output active-low. The polarity, like every other control value, takes effect at a wrap.
- R8: Control bit 6 enables the dead band. The active edge then comes N clocks after the wrap, where N is the count at address 3. If the duty match comes first, the pulse is dropped for that period. The count is captured at every duty match and at every wrap, and each pulse uses the count captured before its wrap.
- R9: Control bit 5 enables the block. While the latched enable is 0, the output sits at its inactive level.
- R10: After reset, all buffers and latches are zero and the output is low. A newly written configuration waits for a wrap before it shapes the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1 duty high, 2 control, 3 dead-band count |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output |

## Verification
A write lands in the buffer at the next clock edge. Its effect on the waveform is only due after the following wrap, and for the dead-band count after up to two wraps. The bench therefore waits a fixed settle time of more than two of the longest periods before it measures anything. The period-dependent results are sampled on falling edges: the active-clock count is taken over a window of exactly two periods, and the length of a pulse is counted from a sampled rising edge of the active level. These counts do not depend on where the window starts relative to the period. The check that a mid-pulse write leaves the pulse alone starts counting on the sample where the active edge is seen, issues the write in that same cycle, and keeps counting until the pulse ends.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
  localparam int TMR_W  = 8;
  localparam int FRAC_W = 2;
  localparam int DUTY_W = TMR_W + FRAC_W;
  localparam int DB_W   = 8;
  localparam int NUM_PS = 3;
  localparam int DIV_W  = FRAC_W * NUM_PS;

  typedef enum logic [1:0] {PS_DIV1 = 2'd0, PS_DIV4 = 2'd1, PS_DIV16 = 2'd2, PS_DIV16B = 2'd3} ps_e;
  typedef enum logic [1:0] {A_PERIOD = 2'd0, A_DUTY_HI = 2'd1, A_CTRL = 2'd2, A_DBAND = 2'd3} addr_e;

  typedef struct packed {
    logic [TMR_W-1:0]  period;
    logic [DUTY_W-1:0] duty;
    ps_e               ps;
    logic              pol;
    logic              en;
    logic              dbe;
    logic [DB_W-1:0]   db;
  } cfg_t;

  // Last divider value of one time-base step: 4*prescale - 1
  function automatic logic [DIV_W-1:0] div_limit(ps_e ps);
    case (ps)
      PS_DIV1: div_limit = DIV_W'(3);
      PS_DIV4: div_limit = DIV_W'(15);
      default: div_limit = DIV_W'(63);
    endcase
  endfunction

  function automatic int ps_index(ps_e ps);
    case (ps)
      PS_DIV1: ps_index = 0;
      PS_DIV4: ps_index = 1;
      default: ps_index = 2;
    endcase
  endfunction
endpackage

// File: rtl/pwm10_regs.sv
module pwm10_regs
  import pwm10_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output cfg_t       cfg_b
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_b <= '0;
    end else if (wr_en) begin
      case (addr_e'(wr_addr))
        A_PERIOD:  cfg_b.period <= wr_data[TMR_W-1:0];
        A_DUTY_HI: cfg_b.duty[DUTY_W-1:FRAC_W] <= wr_data[TMR_W-1:0];
        A_CTRL: begin
          cfg_b.duty[FRAC_W-1:0] <= wr_data[FRAC_W-1:0];
          cfg_b.ps  <= ps_e'(wr_data[3:2]);
          cfg_b.pol <= wr_data[4];
          cfg_b.en  <= wr_data[5];
          cfg_b.dbe <= wr_data[6];
        end
        default:   cfg_b.db <= wr_data[DB_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/pwm10_shadow.sv
module pwm10_shadow
  import pwm10_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic match,
  input  cfg_t cfg_b,
  output cfg_t cfg_a
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_a <= '0;
    end else begin
      if (wrap) begin
        cfg_a.period <= cfg_b.period;
        cfg_a.duty   <= cfg_b.duty;
        cfg_a.ps     <= cfg_b.ps;
        cfg_a.pol    <= cfg_b.pol;
        cfg_a.en     <= cfg_b.en;
        cfg_a.dbe    <= cfg_b.dbe;
      end
      // dead-band count: captured at the duty boundary or the period boundary
      if (wrap || match) cfg_a.db <= cfg_b.db;
    end
  end

  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n) !wrap |=> $stable(cfg_a.duty)); // R2
  AST_POL_HELD:  assert property (@(posedge clk) disable iff (!rst_n) !wrap |=> $stable(cfg_a.pol));  // R7
  AST_EN_HELD:   assert property (@(posedge clk) disable iff (!rst_n) !wrap |=> $stable(cfg_a.en));   // R9
endmodule

// File: rtl/pwm10_timebase.sv
module pwm10_timebase
  import pwm10_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TMR_W-1:0]  period_a,
  input  ps_e               ps_a,
  output logic [TMR_W-1:0]  tmr,
  output logic [FRAC_W-1:0] sub,
  output logic              wrap
);
  logic [DIV_W-1:0]  div_q;
  logic [DIV_W-1:0]  lim;
  logic              tick;
  logic [FRAC_W-1:0] taps [NUM_PS];

  // each prescale option taps its own two-bit slice of the divider
  for (genvar g = 0; g < NUM_PS; g++) begin : g_tap
    assign taps[g] = div_q[FRAC_W*g +: FRAC_W];
  end

  assign lim  = div_limit(ps_a);
  assign tick = (div_q == lim);
  assign wrap = tick && (tmr == period_a);
  assign sub  = taps[ps_index(ps_a)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      tmr   <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (wrap)      tmr <= '0;
      else if (tick) tmr <= tmr + 1'b1;
    end
  end

  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) div_q <= lim);  // R4
  AST_WRAP_CLEARS:  assert property (@(posedge clk) disable iff (!rst_n) wrap |=> tmr == '0); // R1
  AST_TMR_STEP:     assert property (@(posedge clk) disable iff (!rst_n)
                      (tick && !wrap) |=> tmr == $past(tmr) + 1'b1); // R1
  AST_TMR_BOUND:    assert property (@(posedge clk) disable iff (!rst_n)
                      (tmr > period_a) |=> tmr >= $past(tmr)); // R1
endmodule

// File: rtl/pwm10_wave.sv
module pwm10_wave
  import pwm10_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap,
  input  logic [TMR_W-1:0]  tmr,
  input  logic [FRAC_W-1:0] sub,
  input  cfg_t              cfg_b,
  input  cfg_t              cfg_a,
  output logic              match,
  output logic              pwm_out
);
  logic            act_q;
  logic            pend_q;
  logic [DB_W-1:0] dly_q;
  logic            active;
  logic            start_ok;
  logic            use_db;

  assign match    = ({tmr, sub} == cfg_a.duty);
  assign start_ok = cfg_b.en && (cfg_b.duty != '0);
  assign use_db   = cfg_b.dbe && (cfg_a.db != '0);
  assign active   = act_q && !match;
  assign pwm_out  = active ^ cfg_a.pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      dly_q  <= '0;
    end else if (wrap) begin
      act_q  <= start_ok && !use_db;
      pend_q <= start_ok && use_db;
      dly_q  <= cfg_a.db;
    end else if (match) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (pend_q) begin
      if (dly_q == DB_W'(1)) begin
        act_q  <= 1'b1;
        pend_q <= 1'b0;
      end else begin
        dly_q <= dly_q - 1'b1;
      end
    end
  end

  AST_ZERO_DUTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                        (cfg_a.duty == '0) |-> !active); // R5
  AST_DISABLED_IDLE:  assert property (@(posedge clk) disable iff (!rst_n)
                        !cfg_a.en |-> !active); // R9
  AST_DB_HOLDS_EDGE:  assert property (@(posedge clk) disable iff (!rst_n)
                        pend_q |-> !active); // R8
  AST_OVER_PERIOD_ON: assert property (@(posedge clk) disable iff (!rst_n)
                        (wrap && cfg_b.en && !cfg_b.dbe && cfg_b.duty > {cfg_b.period, 2'b11})
                        |=> active); // R6
endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
  import pwm10_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       pwm_out
);
  cfg_t              cfg_b;
  cfg_t              cfg_a;
  logic [TMR_W-1:0]  tmr;
  logic [FRAC_W-1:0] sub;
  logic              wrap;
  logic              match;

  pwm10_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_b(cfg_b)
  );

  pwm10_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .match(match),
    .cfg_b(cfg_b), .cfg_a(cfg_a)
  );

  pwm10_timebase u_tb (
    .clk(clk), .rst_n(rst_n), .period_a(cfg_a.period), .ps_a(cfg_a.ps),
    .tmr(tmr), .sub(sub), .wrap(wrap)
  );

  pwm10_wave u_wave (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .tmr(tmr), .sub(sub),
    .cfg_b(cfg_b), .cfg_a(cfg_a), .match(match), .pwm_out(pwm_out)
  );

  AST_RESET_LOW: assert property (@(posedge clk) $fell(rst_n) |=> !pwm_out); // R10
endmodule

// File: tb/test_pwm10_gen.sv
module test_pwm10_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pwm10_gen i_pwm10_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  // {period, duty_hi, ctrl, dband, period_clocks, high_clocks}
  // ctrl: [6] dband en, [5] enable, [4] active-low, [3:2] prescale, [1:0] duty low
  localparam int NV = 9;
  localparam logic [63:0] VEC [NV] = '{
    {8'h09, 8'h05, 8'h20, 8'h00, 16'd40,  16'd20},  // R3 base case
    {8'h09, 8'h05, 8'h25, 8'h00, 16'd160, 16'd84},  // R4 prescale 4, low bits 1
    {8'h03, 8'h01, 8'h2B, 8'h00, 16'd256, 16'd112}, // R4 prescale 16, low bits 3
    {8'h09, 8'h05, 8'h30, 8'h00, 16'd40,  16'd20},  // R7 active-low
    {8'h09, 8'h05, 8'h60, 8'h05, 16'd40,  16'd15},  // R8 dead band 5
    {8'h09, 8'h00, 8'h20, 8'h00, 16'd40,  16'd0},   // R5 zero duty
    {8'h09, 8'h0F, 8'h20, 8'h00, 16'd40,  16'd40},  // R6 duty beyond period
    {8'h09, 8'h0F, 8'h60, 8'h05, 16'd40,  16'd35},  // R6/R8 over period with dead band
    {8'h09, 8'h01, 8'h60, 8'h06, 16'd40,  16'd0}    // R8 duty ends inside dead band
  };

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_active(int n, bit pol, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out ^ pol) cnt++;
    end
  endtask

  task automatic wait_rise(bit pol, output bit ok);
    bit prev;
    ok = 1'b0;
    prev = pwm_out ^ pol;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (!prev && (pwm_out ^ pol)) begin ok = 1'b1; break; end
      prev = pwm_out ^ pol;
    end
  endtask

  task automatic high_len(bit pol, output int len);
    len = 1;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (pwm_out ^ pol) len++; else break;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    int cnt;
    int len;
    bit ok;
    logic [63:0] v;

    // R10: reset state
    repeat (3) @(negedge clk);
    check(pwm_out == 1'b0, "R10 output low in reset", pwm_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pwm_out == 1'b0, "R10 output low after reset", pwm_out, 0);

    for (int i = 0; i < NV; i++) begin
      int tper;
      int thi;
      bit pol;
      v = VEC[i];
      tper = int'(v[31:16]);
      thi  = int'(v[15:0]);
      pol  = v[36];
      wr(2'd0, v[63:56]);
      wr(2'd1, v[55:48]);
      wr(2'd3, v[39:32]);
      wr(2'd2, v[47:40]);
      repeat (600) @(negedge clk);
      count_active(2 * tper, pol, cnt);
      check(cnt == 2 * thi, $sformatf("R3 vector %0d active clocks per two periods", i), cnt, 2 * thi);
      if (thi > 0 && thi < tper) begin
        wait_rise(pol, ok);
        check(ok, $sformatf("R1 vector %0d first active edge", i), ok, 1);
        len = 0;
        for (int k = 0; k < 4000; k++) begin
          @(negedge clk);
          len++;
          if (pwm_out ^ pol) begin
            if (len > thi) break;
          end
        end
        check(len == tper, $sformatf("R1 vector %0d period clocks", i), len, tper);
      end
    end

    // R2: duty written mid-pulse leaves the running pulse alone
    wr(2'd0, 8'h09);
    wr(2'd1, 8'h05);
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h20);
    repeat (600) @(negedge clk);
    wait_rise(1'b0, ok);
    check(ok, "R2 active edge found", ok, 1);
    wr_addr = 2'd1; wr_data = 8'h02; wr_en = 1'b1;
    len = 1;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (pwm_out) len++; else break;
    end
    check(len == 20, "R2 running pulse keeps old duty", len, 20);
    wait_rise(1'b0, ok);
    high_len(1'b0, len);
    check(len == 8, "R2 next pulse uses new duty", len, 8);

    // R9: disabled with active-low polarity sits at inactive level (high)
    wr(2'd2, 8'h10);
    repeat (600) @(negedge clk);
    count_active(100, 1'b0, cnt);
    check(cnt == 100, "R9 disabled output at inactive level", cnt, 100);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule